// File: doc/BRIEF.md
# IR run-length sample accumulator

This block sits behind the receive FIFO of an infrared receiver. The receiver front end samples the demodulated line once per cell and writes one byte per cell into the FIFO. The top bit of each byte tells whether the line was marked (carrier present) or spaced. The low seven bits count ticks of 10 microseconds. The block reads these bytes and folds consecutive bytes of equal polarity into one running duration. Each time the polarity flips, it hands the finished run downstream as a single event that carries a polarity and a total duration. A protocol decoder further down the chain consumes these events.

Bytes arrive in groups of eight, because the FIFO raises its request at its half-level mark. A group made only of all-zero and all-one bytes means the line has gone quiet. The block then flushes the run it still holds, swallows whatever is left in the FIFO, and returns to idle. An overflow or underflow strobe from the FIFO poisons the current transmission. Bytes are still counted and checked for the quiet condition, but they produce no events until the transmission ends. An activity flag can drive a receive LED.

Top module: `ir_rl_acc`

## Requirements
- R1: After reset, `s_ready` is 1, `evt_valid` is 0 and `rx_active` is 0.
- R2: In each sample byte, bit 7 = 0 means mark and bit 7 = 1 means space. Bits 6:0 give the duration in 10 us ticks. Events report a mark as `evt_mark` = 1 and a space as `evt_mark` = 0. `evt_dur` is in the same ticks.
- R3: Accepted samples whose polarity matches the running run add their ticks to it, and no event is produced.
- R4: If an accepted sample has the opposite polarity and the running total is nonzero, the block emits one event with the old polarity and the total, then restarts the run with the new sample. If the total is zero, only the polarity changes. `evt_dur` is never 0 while `evt_valid` is 1.
- R5: Samples are counted in groups of `GROUP_LEN` (8). If every byte of a group is 0x00 or 0xFF, the transmission ends. The group's bytes are folded in first, and then any nonzero run is emitted and the run is cleared. A group containing any other byte does not end the transmission.
- R6: After an end of transmission, samples offered with `s_valid` held high are accepted and discarded. Normal intake resumes after the first cycle with `s_valid` low, starting a fresh group.
- R7: A one-cycle `err_in` pulse discards the running total and sets a sticky error. While the error is set, samples produce no events but are still grouped and checked for end of transmission. The error clears at end of transmission, and that ending emits no event.
- R8: `rx_active` rises after the first sample accepted while idle. It falls when the end-of-transmission flush completes.
- R9: `evt_mark` and `evt_dur` hold steady while `evt_valid` is 1 and `evt_ready` is 0. During normal intake, `s_ready` is 0 whenever an event is waiting.
- R10: The running total saturates at 2^`DUR_W` - 1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | FIFO byte available |
| s_ready | output | 1 | Byte taken at this edge when `s_valid` is also high |
| s_data | input | 8 | Receiver sample: polarity bit 7, ticks 6:0 |
| err_in | input | 1 | FIFO overflow/underflow strobe |
| evt_valid | output | 1 | Event held on `evt_mark`/`evt_dur` |
| evt_ready | input | 1 | Consumer takes the event |
| evt_mark | output | 1 | 1 for mark, 0 for space |
| evt_dur | output | DUR_W | Run length in 10 us ticks |
| rx_active | output | 1 | Transmission in progress |

## Verification
The bench drives several kinds of group and compares them against its own reference model on every clock:
- Mixed mark and space groups show that runs are merged and split at the right polarity flips.
- Groups of pure 0x00/0xFF bytes, compared with a group that is quiet except for one byte, show the end-of-transmission condition apart from an ordinary quiet stretch.
- Junk bytes fed straight after an ending prove the drain, because any event they caused would have no match in the model.
- An error pulse in the middle of a group, and a run long enough to overflow a narrowed accumulator, cover suppression and saturation.
- Consumer back-pressure varies from none to total, which shows that the intake stall never loses or reorders a run.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

    localparam int SAMPLE_W = 8;
    localparam int TICK_W   = 7;

    typedef struct packed {
        logic             space;
        logic [TICK_W-1:0] ticks;
    } rl_sample_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DRAIN = 2'd2
    } rl_state_e;

    // A quiet-line byte is all zeros or all ones.
    function automatic logic quiet_byte(input logic [SAMPLE_W-1:0] b);
        return (b == '0) || (b == '1);
    endfunction

endpackage

// File: rtl/ir_rl_classify.sv
module ir_rl_classify
    import ir_rl_pkg::*;
(
    input  logic [SAMPLE_W-1:0] raw,
    output logic                mark,
    output logic [TICK_W-1:0]   ticks,
    output logic                quiet
);
    rl_sample_t smp;

    always_comb begin
        smp   = rl_sample_t'(raw);
        mark  = ~smp.space;
        ticks = smp.ticks;
        quiet = quiet_byte(raw);
    end
endmodule

// File: rtl/ir_rl_accum.sv
module ir_rl_accum
    import ir_rl_pkg::*;
#(
    parameter int DUR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              s_mark,
    input  logic [TICK_W-1:0] s_ticks,
    input  logic              drop,
    input  logic              flush_go,
    input  logic              evt_ready,
    output logic              evt_valid,
    output logic              evt_mark,
    output logic [DUR_W-1:0]  evt_dur
);
    localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

    logic             run_mark;
    logic [DUR_W-1:0] run_dur;
    logic [DUR_W-1:0] tick_ext;
    logic [DUR_W:0]   sum_wide;
    logic [DUR_W-1:0] sum_sat;
    logic             run_live;

    always_comb begin
        tick_ext = {{(DUR_W-TICK_W){1'b0}}, s_ticks};
        sum_wide = {1'b0, run_dur} + {1'b0, tick_ext};
        sum_sat  = sum_wide[DUR_W] ? DUR_MAX : sum_wide[DUR_W-1:0];
        run_live = (run_dur != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_mark  <= 1'b0;
            run_dur   <= '0;
            evt_valid <= 1'b0;
            evt_mark  <= 1'b0;
            evt_dur   <= '0;
        end else begin
            if (evt_valid && evt_ready) begin
                evt_valid <= 1'b0;
            end
            if (drop) begin
                run_dur <= '0;
            end else if (flush_go) begin
                if (run_live) begin
                    evt_valid <= 1'b1;
                    evt_mark  <= run_mark;
                    evt_dur   <= run_dur;
                end
                run_dur <= '0;
            end else if (take) begin
                if (s_mark != run_mark) begin
                    if (run_live) begin
                        evt_valid <= 1'b1;
                        evt_mark  <= run_mark;
                        evt_dur   <= run_dur;
                    end
                    run_mark <= s_mark;
                    run_dur  <= tick_ext;
                end else begin
                    run_dur <= sum_sat;
                end
            end
        end
    end
endmodule

// File: rtl/ir_rl_seq.sv
module ir_rl_seq
    import ir_rl_pkg::*;
#(
    parameter int GROUP_LEN = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      s_valid,
    input  logic      s_quiet,
    input  logic      err_in,
    input  logic      evt_valid,
    output logic      s_ready,
    output logic      take,
    output logic      flush_go,
    output logic      rx_active,
    output rl_state_e st
);
    localparam int CNT_W = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_LEN - 1);

    logic [CNT_W-1:0] grp_cnt;
    logic             grp_quiet;
    logic             err_flag;
    logic             accept;

    always_comb begin
        s_ready  = ((st == ST_RUN) && !evt_valid) || (st == ST_DRAIN);
        accept   = s_valid && s_ready;
        take     = accept && (st == ST_RUN) && !err_flag && !err_in;
        flush_go = (st == ST_FLUSH) && !evt_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RUN;
            grp_cnt   <= '0;
            grp_quiet <= 1'b1;
            err_flag  <= 1'b0;
            rx_active <= 1'b0;
        end else begin
            if (flush_go) begin
                err_flag <= err_in;
            end else if (err_in) begin
                err_flag <= 1'b1;
            end
            unique case (st)
                ST_RUN: begin
                    if (accept) begin
                        rx_active <= 1'b1;
                        if (grp_cnt == LAST_IDX) begin
                            grp_cnt   <= '0;
                            grp_quiet <= 1'b1;
                            if (grp_quiet && s_quiet) begin
                                st <= ST_FLUSH;
                            end
                        end else begin
                            grp_cnt   <= grp_cnt + 1'b1;
                            grp_quiet <= grp_quiet && s_quiet;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (!evt_valid) begin
                        st        <= ST_DRAIN;
                        rx_active <= 1'b0;
                    end
                end
                ST_DRAIN: begin
                    if (!s_valid) begin
                        st <= ST_RUN;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/ir_rl_acc.sv
module ir_rl_acc
    import ir_rl_pkg::*;
#(
    parameter int DUR_W     = 24,
    parameter int GROUP_LEN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_data,
    input  logic                err_in,
    output logic                evt_valid,
    input  logic                evt_ready,
    output logic                evt_mark,
    output logic [DUR_W-1:0]    evt_dur,
    output logic                rx_active
);
    logic              smp_mark;
    logic [TICK_W-1:0] smp_ticks;
    logic              smp_quiet;
    logic              take;
    logic              flush_go;
    rl_state_e         st;
    logic              run_st;

    assign run_st = (st == ST_RUN);

    ir_rl_classify u_cls (
        .raw   (s_data),
        .mark  (smp_mark),
        .ticks (smp_ticks),
        .quiet (smp_quiet)
    );

    ir_rl_seq #(.GROUP_LEN(GROUP_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (s_valid),
        .s_quiet   (smp_quiet),
        .err_in    (err_in),
        .evt_valid (evt_valid),
        .s_ready   (s_ready),
        .take      (take),
        .flush_go  (flush_go),
        .rx_active (rx_active),
        .st        (st)
    );

    ir_rl_accum #(.DUR_W(DUR_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .s_mark    (smp_mark),
        .s_ticks   (smp_ticks),
        .drop      (err_in),
        .flush_go  (flush_go),
        .evt_ready (evt_ready),
        .evt_valid (evt_valid),
        .evt_mark  (evt_mark),
        .evt_dur   (evt_dur)
    );
endmodule

// File: rtl/ir_rl_acc_chk.sv
module ir_rl_acc_chk #(
    parameter int DUR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             s_valid,
    input logic             s_ready,
    input logic             evt_valid,
    input logic             evt_ready,
    input logic             evt_mark,
    input logic [DUR_W-1:0] evt_dur,
    input logic             rx_active,
    input logic             in_run
);
    a_r9_event_hold: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_mark) && $stable(evt_dur)))
        else $error("R9 event changed while stalled");

    a_r9_intake_stall: assert property (@(posedge clk) disable iff (rst)
        (in_run && evt_valid) |-> !s_ready)
        else $error("R9 intake open with event waiting");

    a_r4_nonzero_event: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_dur != '0))
        else $error("R4 zero-length event");

    a_r8_active_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> $past(s_valid && s_ready))
        else $error("R8 activity rose without intake");

    a_r8_active_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_active) |-> !in_run)
        else $error("R8 activity fell outside flush");
endmodule

bind ir_rl_acc ir_rl_acc_chk #(.DUR_W(DUR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_mark  (evt_mark),
    .evt_dur   (evt_dur),
    .rx_active (rx_active),
    .in_run    (run_st)
);

// File: tb/ir_rl_acc_tb_top.sv
module ir_rl_acc_tb_top;
    localparam int DW   = 10;
    localparam int MAXD = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [7:0]    s_data = 8'h00;
    logic          err_in = 1'b0;
    logic          evt_valid;
    logic          evt_ready = 1'b0;
    logic          evt_mark;
    logic [DW-1:0] evt_dur;
    logic          rx_active;

    always #10 clk = ~clk;

    ir_rl_acc #(.DUR_W(DW), .GROUP_LEN(8)) dut_i (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .err_in(err_in), .evt_valid(evt_valid),
        .evt_ready(evt_ready), .evt_mark(evt_mark), .evt_dur(evt_dur),
        .rx_active(rx_active)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int bp    = 0;
    int last_dur = 0;
    bit done  = 0;

    // reference model state
    bit m_mark = 0;
    int m_dur  = 0;
    bit m_err  = 0;
    int m_cnt  = 0;
    bit m_quiet = 1;
    bit q_mark[$];
    int q_dur[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic m_emit(input bit mk, input int d);
        q_mark.push_back(mk);
        q_dur.push_back(d);
    endtask

    task automatic m_sample(input logic [7:0] b);
        bit mk;
        int t;
        mk = ~b[7];
        t  = int'(b[6:0]);
        m_cnt++;
        m_quiet = m_quiet && (b == 8'h00 || b == 8'hFF);
        if (!m_err) begin
            if (mk != m_mark) begin
                if (m_dur != 0) m_emit(m_mark, m_dur);
                m_mark = mk;
                m_dur  = t;
            end else begin
                m_dur = (m_dur + t > MAXD) ? MAXD : m_dur + t;
            end
        end
        if (m_cnt == 8) begin
            if (m_quiet) begin
                if (m_dur != 0 && !m_err) m_emit(m_mark, m_dur);
                m_dur = 0;
                m_err = 0;
            end
            m_cnt   = 0;
            m_quiet = 1;
        end
    endtask

    // event sink and per-clock comparison
    always @(negedge clk) begin
        if (!rst) begin
            bit r;
            case (bp)
                0: r = 1'b1;
                1: r = (cyc % 4 == 0);
                2: r = 1'b0;
                default: r = (cyc % 3 != 0);
            endcase
            evt_ready = r;
            if (evt_valid && r) begin
                if (q_mark.size() == 0) begin
                    chk(0, "R4 unexpected event", int'(evt_dur), 0);
                end else begin
                    bit em;
                    int ed;
                    em = q_mark.pop_front();
                    ed = q_dur.pop_front();
                    chk(evt_mark == em, "R2 R4 event polarity", int'(evt_mark), int'(em));
                    chk(int'(evt_dur) == ed, "R3 R4 event duration", int'(evt_dur), ed);
                    last_dur = int'(evt_dur);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic push(input logic [7:0] b, input bit mdl);
        s_data  = b;
        s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        if (mdl) m_sample(b);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic push_n(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) push(b, 1);
    endtask

    task automatic end_wait();
        while (rx_active) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 60; i++) begin
            if (q_mark.size() == 0 && !evt_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_err();
        err_in = 1'b1;
        m_err  = 1;
        m_dur  = 0;
        @(negedge clk);
        err_in = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk(s_ready == 1'b1, "R1 s_ready after reset", int'(s_ready), 1);
        chk(evt_valid == 1'b0, "R1 evt_valid after reset", int'(evt_valid), 0);
        chk(rx_active == 1'b0, "R1 rx_active after reset", int'(rx_active), 0);

        // mixed runs, then quiet group of spaces
        push(8'h05, 1);
        chk(rx_active == 1'b1, "R8 active after first sample", int'(rx_active), 1);
        push(8'h03, 1); push(8'h85, 1); push(8'h90, 1);
        push(8'h10, 1); push(8'h10, 1); push(8'h82, 1); push(8'h01, 1);
        push_n(8'hFF, 8);
        end_wait();
        chk(rx_active == 1'b0, "R8 inactive after end", int'(rx_active), 0);
        settle();
        chk(q_mark.size() == 0, "R5 all events flushed", q_mark.size(), 0);

        // back-pressure, non-quiet group then mixed quiet group
        bp = 1;
        push(8'h7F, 1); push(8'h7F, 1); push(8'hFF, 1); push(8'h7F, 1);
        push(8'h00, 1); push(8'hFF, 1); push(8'h00, 1); push(8'hFF, 1);
        push(8'h00, 1); push(8'hFF, 1); push(8'h00, 1); push(8'hFF, 1);
        push(8'hFF, 1); push(8'h00, 1); push(8'h00, 1); push(8'hFF, 1);
        end_wait();
        settle();
        chk(q_mark.size() == 0, "R5 mixed quiet group ends", q_mark.size(), 0);
        bp = 3;

        // almost quiet group must not end the transmission
        push_n(8'hFF, 7);
        push(8'h81, 1);
        repeat (4) @(negedge clk);
        chk(rx_active == 1'b1, "R5 near-quiet group keeps active", int'(rx_active), 1);
        push_n(8'h00, 8);
        end_wait();
        settle();

        // stall while an event waits
        bp = 2;
        push(8'h10, 1);
        push(8'h90, 1);
        chk(evt_valid == 1'b1, "R9 event pending", int'(evt_valid), 1);
        chk(s_ready == 1'b0, "R9 intake stalled", int'(s_ready), 0);
        repeat (3) @(negedge clk);
        chk(evt_valid == 1'b1 && evt_dur == 10'd16, "R9 event held", int'(evt_dur), 16);
        bp = 0;
        push(8'h11, 1); push(8'h12, 1); push(8'h93, 1); push(8'h14, 1);
        push(8'h95, 1); push(8'h16, 1);
        push_n(8'hFF, 8);
        end_wait();
        settle();

        // error in mid-group suppresses events until the end
        bp = 3;
        push(8'h20, 1); push(8'h20, 1);
        pulse_err();
        push(8'h30, 1); push(8'hB0, 1); push(8'h31, 1); push(8'hB1, 1);
        push(8'h32, 1); push(8'hB2, 1);
        push_n(8'hFF, 8);
        end_wait();
        settle();
        chk(q_mark.size() == 0 && !evt_valid, "R7 no events under error", int'(evt_valid), 0);
        push(8'h44, 1); push(8'hC4, 1);
        push_n(8'hFF, 6);
        push_n(8'hFF, 8);
        end_wait();
        settle();
        chk(q_mark.size() == 0, "R7 events resume after error", q_mark.size(), 0);

        // saturation
        push_n(8'h7F, 16);
        push_n(8'hFF, 8);
        end_wait();
        settle();
        chk(last_dur == MAXD || q_mark.size() == 0, "R10 saturated run", last_dur, MAXD);

        // drain of junk after an end
        push_n(8'h05, 8);
        push_n(8'hFF, 8);
        push(8'h12, 0); push(8'h92, 0); push(8'h33, 0);
        end_wait();
        chk(rx_active == 1'b0, "R6 junk did not reactivate", int'(rx_active), 0);
        push_n(8'h06, 8);
        push_n(8'hFF, 8);
        end_wait();
        settle();
        chk(q_mark.size() == 0 && !evt_valid, "R6 junk discarded", q_mark.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule